// File: doc/BRIEF.md
# Synchronizable Multi-Channel PWM Timer

A pulse-width modulation timer for multi-phase motor drive. A prescaler divides the system clock, and each prescale tick advances a period counter that runs from zero up to a programmed limit and then wraps. Every output channel has two compare values of its own. One marks where the output rises and the other marks where it falls, so the pulses of all phases can be placed freely within the period. A trap input pulls every output low at once for fault shutdown. Capture inputs record the counter value on external edges.

Configuration is written through a small word-addressed register port into a shadow set. While the timer is stopped, the active set follows the shadow set directly. While it runs, the shadow set is copied only at the wrap of the period counter, and only when a local transfer bit and a transfer-enable input are both high. The same condition is passed on through a transfer-enable output, so that a master timer can control the updates of the timers after it. A sync output pulses at a programmable count within each period. In slave mode a sync input restarts the counters. Together these let several timers form a phase-locked chain.

Top module: `pwm_sync_timer`

## Requirements
- R1: After reset, cnt_o is 0, every pwm_o bit is 0, sync_o is 0, trans_en_o is 0 and the capture flag register (address 4) reads 0.
- R2: While control bit 0 (run) is 1, cnt_o advances once every (prescale limit + 1) clocks, where the prescale limit is at address 1. While run is 0, cnt_o holds its value.
- R3: When the period counter reaches the period limit (address 2) and a prescale tick occurs, the counter goes to 0 at the next count.
- R4: Channel c has its rise value at address 8+2c and its fall value at address 9+2c. The output goes high once the counter equals the rise value and low once it equals the fall value. Over one period it is high for (fall-rise)·(prescale+1) clocks when rise<fall, and for (period+1-rise+fall)·(prescale+1) clocks when rise>fall.
- R5: When a channel's rise value equals its fall value, that output stays low for the whole period.
- R6: While running, shadow writes take effect only at a period wrap where control bit 1 (transfer) and trans_en_i are both 1. trans_en_o equals control bit 1 AND trans_en_i. While run is 0, writes take effect at once.
- R7: While trap_i is 1, every pwm_o bit is 0 in the same cycle. After trap_i is released, an output stays low until its next rise match.
- R8: A rising edge on cap_i[k] loads the current counter value into the capture register at address 16+k and sets bit k of the flag register (address 4). Writing 1 to a flag bit clears it.
- R9: sync_o is high for exactly one clock: the first clock in which cnt_o shows the sync delay value (address 3). It repeats once per period.
- R10: With control bit 2 (slave) set, sync_i high clears both counters at the next clock edge. With bit 2 clear, sync_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write word address |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 5 | Read word address |
| rd_data_o | output | CNT_W | Read data, combinational from rd_addr_i |
| cap_i | input | NUM_CAP | Capture event inputs, rising edge active |
| trap_i | input | 1 | Forces all outputs low |
| sync_i | input | 1 | Counter restart from a master timer |
| sync_o | output | 1 | Period sync pulse to a slave timer |
| trans_en_i | input | 1 | Transfer permission from the previous timer |
| trans_en_o | output | 1 | Transfer permission to the next timer |
| cnt_o | output | CNT_W | Current period counter value |
| pwm_o | output | NUM_CH | PWM outputs |

## Verification
The assertions assume that all inputs are synchronous to clk_i and that cap_i is low during reset, so that the first edge seen after reset is a real one. They also assume that the configured compare and sync values do not exceed the period limit. The bench changes every input only at the falling clock edge and keeps cap_i, sync_i and trap_i low through reset. Each scenario first writes its configuration with the timer stopped, and every compare value it programs lies within the period it sets.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL     = 5'd0;
  localparam logic [ADDR_W-1:0] A_PSC      = 5'd1;
  localparam logic [ADDR_W-1:0] A_PER      = 5'd2;
  localparam logic [ADDR_W-1:0] A_SYNC     = 5'd3;
  localparam logic [ADDR_W-1:0] A_CAPF     = 5'd4;
  localparam int                A_CMP_BASE = 8;
  localparam int                A_CAP_BASE = 16;

  typedef struct packed {
    logic slave;
    logic xfer;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_sync_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_CAP = 2,
  parameter int W       = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [W-1:0]                  wr_data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [W-1:0]                  rd_data_o,
  input  logic                          wrap_i,
  input  logic                          trans_en_i,
  output logic                          trans_en_o,
  input  logic [NUM_CAP-1:0][W-1:0]     cap_val_i,
  input  logic [NUM_CAP-1:0]            cap_flag_i,
  output logic [NUM_CAP-1:0]            cap_clr_o,
  output ctrl_t                         ctrl_o,
  output logic [W-1:0]                  psc_a_o,
  output logic [W-1:0]                  per_a_o,
  output logic [W-1:0]                  sync_a_o,
  output logic [NUM_CH-1:0][W-1:0]      rise_a_o,
  output logic [NUM_CH-1:0][W-1:0]      fall_a_o
);
  ctrl_t                     ctrl_q;
  logic [W-1:0]              psc_s, per_s, sync_s;
  logic [NUM_CH-1:0][W-1:0]  rise_s, fall_s;
  logic                      xfer_ok, copy;

  assign xfer_ok    = ctrl_q.xfer & trans_en_i;
  assign trans_en_o = xfer_ok;
  // idle timer tracks shadow; running timer loads only at a permitted wrap
  assign copy       = ~ctrl_q.run | (wrap_i & xfer_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      psc_s    <= '0;
      per_s    <= '1;
      sync_s   <= '0;
      rise_s   <= '0;
      fall_s   <= '0;
      psc_a_o  <= '0;
      per_a_o  <= '1;
      sync_a_o <= '0;
      rise_a_o <= '0;
      fall_a_o <= '0;
    end else begin
      if (wr_en_i) begin
        case (wr_addr_i)
          A_CTRL:  ctrl_q <= ctrl_t'(wr_data_i[2:0]);
          A_PSC:   psc_s  <= wr_data_i;
          A_PER:   per_s  <= wr_data_i;
          A_SYNC:  sync_s <= wr_data_i;
          default: ;
        endcase
        for (int c = 0; c < NUM_CH; c++) begin
          if (wr_addr_i == ADDR_W'(A_CMP_BASE + 2*c))     rise_s[c] <= wr_data_i;
          if (wr_addr_i == ADDR_W'(A_CMP_BASE + 2*c + 1)) fall_s[c] <= wr_data_i;
        end
      end
      if (copy) begin
        psc_a_o  <= psc_s;
        per_a_o  <= per_s;
        sync_a_o <= sync_s;
        rise_a_o <= rise_s;
        fall_a_o <= fall_s;
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign cap_clr_o = (wr_en_i && wr_addr_i == A_CAPF) ? wr_data_i[NUM_CAP-1:0] : '0;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL:  rd_data_o = W'(ctrl_q);
      A_PSC:   rd_data_o = psc_s;
      A_PER:   rd_data_o = per_s;
      A_SYNC:  rd_data_o = sync_s;
      A_CAPF:  rd_data_o = W'(cap_flag_i);
      default: ;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr_i == ADDR_W'(A_CMP_BASE + 2*c))     rd_data_o = rise_s[c];
      if (rd_addr_i == ADDR_W'(A_CMP_BASE + 2*c + 1)) rd_data_o = fall_s[c];
    end
    for (int k = 0; k < NUM_CAP; k++) begin
      if (rd_addr_i == ADDR_W'(A_CAP_BASE + k)) rd_data_o = cap_val_i[k];
    end
  end
endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         restart_i,
  input  logic [W-1:0] psc_lim_i,
  input  logic [W-1:0] per_lim_i,
  input  logic [W-1:0] sync_dly_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         sync_o
);
  logic [W-1:0] psc_q, cnt_q, cnt_nxt;
  logic         tick, at_top;

  assign tick    = run_i & (psc_q >= psc_lim_i);
  assign at_top  = cnt_q >= per_lim_i;
  assign cnt_nxt = at_top ? '0 : cnt_q + 1'b1;
  assign wrap_o  = tick & at_top & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      cnt_q  <= '0;
      sync_o <= 1'b0;
    end else if (restart_i) begin
      psc_q  <= '0;
      cnt_q  <= '0;
      sync_o <= 1'b0;
    end else if (tick) begin
      psc_q  <= '0;
      cnt_q  <= cnt_nxt;
      sync_o <= (cnt_nxt == sync_dly_i);
    end else begin
      if (run_i) psc_q <= psc_q + 1'b1;
      sync_o <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic         trap_i,
  output logic         pwm_o
);
  logic out_q;

  // fall wins over rise, so equal values give a flat low output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                out_q <= 1'b0;
    else if (trap_i)            out_q <= 1'b0;
    else if (cnt_i == fall_i)   out_q <= 1'b0;
    else if (cnt_i == rise_i)   out_q <= 1'b1;
  end

  assign pwm_o = out_q & ~trap_i;
endmodule

// File: rtl/pwm_cap.sv
module pwm_cap #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] cnt_i,
  input  logic         clr_i,
  output logic [W-1:0] val_o,
  output logic         flag_o
);
  logic prev_q, evt;

  assign evt = cap_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      val_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      prev_q <= cap_i;
      if (evt) val_o <= cnt_i;
      if (evt)        flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_sync_timer.sv
module pwm_sync_timer
  import pwm_sync_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_CAP = 2,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [CNT_W-1:0]   rd_data_o,
  input  logic [NUM_CAP-1:0] cap_i,
  input  logic               trap_i,
  input  logic               sync_i,
  output logic               sync_o,
  input  logic               trans_en_i,
  output logic               trans_en_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [NUM_CH-1:0]  pwm_o
);
  ctrl_t                            ctrl;
  logic [CNT_W-1:0]                 psc_a, per_a, sync_a;
  logic [NUM_CH-1:0][CNT_W-1:0]     rise_a, fall_a;
  logic [NUM_CAP-1:0][CNT_W-1:0]    cap_val;
  logic [NUM_CAP-1:0]               cap_flag, cap_clr;
  logic                             wrap, restart;

  assign restart = sync_i & ctrl.slave;

  pwm_regs #(.NUM_CH(NUM_CH), .NUM_CAP(NUM_CAP), .W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .wrap_i(wrap), .trans_en_i, .trans_en_o,
    .cap_val_i(cap_val), .cap_flag_i(cap_flag), .cap_clr_o(cap_clr),
    .ctrl_o(ctrl), .psc_a_o(psc_a), .per_a_o(per_a), .sync_a_o(sync_a),
    .rise_a_o(rise_a), .fall_a_o(fall_a)
  );

  pwm_count #(.W(CNT_W)) i_count (
    .clk_i, .rst_ni, .run_i(ctrl.run), .restart_i(restart),
    .psc_lim_i(psc_a), .per_lim_i(per_a), .sync_dly_i(sync_a),
    .cnt_o, .wrap_o(wrap), .sync_o
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan #(.W(CNT_W)) i_chan (
      .clk_i, .rst_ni, .cnt_i(cnt_o), .rise_i(rise_a[c]), .fall_i(fall_a[c]),
      .trap_i, .pwm_o(pwm_o[c])
    );
  end

  for (genvar k = 0; k < NUM_CAP; k++) begin : g_cap
    pwm_cap #(.W(CNT_W)) i_cap (
      .clk_i, .rst_ni, .cap_i(cap_i[k]), .cnt_i(cnt_o), .clr_i(cap_clr[k]),
      .val_o(cap_val[k]), .flag_o(cap_flag[k])
    );
  end
endmodule

// File: rtl/pwm_sync_timer_chk.sv
module pwm_sync_timer_chk #(
  parameter int NUM_CH  = 4,
  parameter int NUM_CAP = 2,
  parameter int CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               run_i,
  input logic               restart_i,
  input logic               wrap_i,
  input logic [CNT_W-1:0]   sync_a_i,
  input logic [CNT_W-1:0]   cnt_o,
  input logic [NUM_CH-1:0]  pwm_o,
  input logic               trap_i,
  input logic               sync_o,
  input logic               trans_en_i,
  input logic               trans_en_o,
  input logic [NUM_CAP-1:0] cap_i,
  input logic [NUM_CAP-1:0] cap_flag_i
);
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_i) && !$past(restart_i)) |-> $stable(cnt_o)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wrap_i) |-> (cnt_o == '0)); // R3
  AST_XFER_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_en_o |-> trans_en_i); // R6
  AST_TRAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |-> (pwm_o == '0)); // R7
  AST_TRAP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trap_i) |-> (pwm_o == '0)); // R7
  AST_CAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cap_i & ~$past(cap_i)) != '0) |=> (cap_flag_i != '0)); // R8
  AST_SYNC_AT_DLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (cnt_o == $past(sync_a_i))); // R9
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(restart_i) |-> (cnt_o == '0 && !sync_o)); // R10
endmodule

bind pwm_sync_timer pwm_sync_timer_chk #(
  .NUM_CH(NUM_CH), .NUM_CAP(NUM_CAP), .CNT_W(CNT_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl.run), .restart_i(restart),
  .wrap_i(wrap), .sync_a_i(sync_a), .cnt_o(cnt_o), .pwm_o(pwm_o),
  .trap_i(trap_i), .sync_o(sync_o), .trans_en_i(trans_en_i),
  .trans_en_o(trans_en_o), .cap_i(cap_i), .cap_flag_i(cap_flag)
);

// File: tb/test_pwm_sync_timer.sv
module test_pwm_sync_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4, NUM_CAP = 2, CNT_W = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [CNT_W-1:0] wr_data = '0, rd_data, cnt;
  logic [NUM_CAP-1:0] cap = '0;
  logic trap = 1'b0, sync_in = 1'b0, sync_out, ten_in = 1'b1, ten_out;
  logic [NUM_CH-1:0] pwm;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_sync_timer #(.NUM_CH(NUM_CH), .NUM_CAP(NUM_CAP), .CNT_W(CNT_W)) i_pwm_sync_timer (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cap_i(cap), .trap_i(trap),
    .sync_i(sync_in), .sync_o(sync_out), .trans_en_i(ten_in), .trans_en_o(ten_out),
    .cnt_o(cnt), .pwm_o(pwm)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    rd_addr = 5'(a);
    #1 d = int'(rd_data);
  endtask

  task automatic wait_cnt(string req, int v);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (int'(cnt) == v) return;
    end
    chk(req, int'(cnt), v);
  endtask

  task automatic high_clocks(int ch, int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm[ch]) h++;
    end
  endtask

  // stop, program one channel and timing, then run
  task automatic setup(int psc, int per, int rise, int fall, int ctrl_run);
    wr(0, 0);
    wr(1, psc); wr(2, per); wr(8, rise); wr(9, fall);
    wr(0, ctrl_run);
  endtask

  task automatic t_reset();
    int d;
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 pwm", int'(pwm), 0);
    chk("R1 sync_o", int'(sync_out), 0);
    chk("R1 trans_en_o", int'(ten_out), 0);
    rd(4, d); chk("R1 flags", d, 0);
  endtask

  task automatic t_prescale();
    int n, v;
    setup(2, 9, 20, 20, 1);
    wait_cnt("R2 sync", 3);
    v = int'(cnt); n = 0;
    while (int'(cnt) == v && n < 100) begin @(negedge clk); n++; end
    chk("R2 clocks per count", n, 3);
    wr(0, 0);
    v = int'(cnt);
    repeat (12) @(negedge clk);
    chk("R2 hold when stopped", int'(cnt), v);
  endtask

  task automatic t_wrap();
    setup(0, 4, 20, 20, 1);
    wait_cnt("R3 reach limit", 4);
    @(negedge clk);
    chk("R3 wrap to zero", int'(cnt), 0);
    @(negedge clk);
    chk("R3 count after wrap", int'(cnt), 1);
  endtask

  task automatic t_duty();
    int h;
    setup(0, 9, 2, 5, 1);
    repeat (20) @(negedge clk);
    high_clocks(0, 10, h); chk("R4 duty rise<fall", h, 3);
    setup(1, 9, 2, 5, 1);
    repeat (40) @(negedge clk);
    high_clocks(0, 20, h); chk("R4 duty prescaled", h, 6);
    setup(0, 9, 7, 2, 1);
    repeat (20) @(negedge clk);
    high_clocks(0, 10, h); chk("R4 duty rise>fall", h, 5);
  endtask

  task automatic t_equal();
    int h;
    setup(0, 9, 4, 4, 1);
    repeat (20) @(negedge clk);
    high_clocks(0, 30, h); chk("R5 equal compare low", h, 0);
  endtask

  task automatic t_shadow();
    int h;
    ten_in = 1'b1;
    setup(0, 9, 2, 5, 1);
    repeat (20) @(negedge clk);
    wr(9, 8);
    repeat (25) @(negedge clk);
    high_clocks(0, 10, h); chk("R6 no transfer keeps old", h, 3);
    ten_in = 1'b0;
    wr(0, 3);
    chk("R6 trans_en_o blocked", int'(ten_out), 0);
    repeat (25) @(negedge clk);
    high_clocks(0, 10, h); chk("R6 chain blocks transfer", h, 3);
    ten_in = 1'b1;
    #1 chk("R6 trans_en_o passes", int'(ten_out), 1);
    repeat (25) @(negedge clk);
    high_clocks(0, 10, h); chk("R6 transfer applied", h, 6);
    wr(0, 0);
  endtask

  task automatic t_trap();
    int h;
    setup(0, 9, 1, 6, 1);
    repeat (20) @(negedge clk);
    wait_cnt("R7 sync", 4);
    chk("R7 high before trap", int'(pwm[0]), 1);
    trap = 1'b1;
    #1 chk("R7 trap forces low", int'(pwm), 0);
    wait_cnt("R7 sync2", 3);
    trap = 1'b0;
    high_clocks(0, 3, h); chk("R7 low after release", h, 0);
    repeat (10) @(negedge clk);
    high_clocks(0, 10, h); chk("R7 resumes at rise", h, 5);
  endtask

  task automatic t_capture();
    int v, d;
    setup(0, 99, 20, 20, 1);
    wait_cnt("R8 sync", 37);
    wr(0, 0);
    v = int'(cnt);
    cap[1] = 1'b1;
    @(negedge clk);
    cap[1] = 1'b0;
    @(negedge clk);
    rd(17, d); chk("R8 captured value", d, v);
    rd(16, d); chk("R8 other capture untouched", d, 0);
    rd(4, d);  chk("R8 flag set", d, 2);
    wr(4, 1);
    rd(4, d);  chk("R8 write 1 to other bit", d, 2);
    wr(4, 2);
    rd(4, d);  chk("R8 flag cleared", d, 0);
  endtask

  task automatic t_sync_out();
    int n;
    wr(0, 0); wr(3, 3);
    setup(1, 9, 20, 20, 1);
    n = 0;
    while (!sync_out && n < 1000) begin @(negedge clk); n++; end
    chk("R9 sync_o at delay", int'(cnt), 3);
    @(negedge clk);
    chk("R9 pulse one clock", int'(sync_out), 0);
    n = 1;
    while (!sync_out && n < 1000) begin @(negedge clk); n++; end
    chk("R9 pulse spacing", n, 20);
  endtask

  task automatic t_sync_in();
    setup(0, 99, 20, 20, 5);
    wait_cnt("R10 sync", 50);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    chk("R10 slave restart", int'(cnt), 0);
    wr(0, 1);
    wait_cnt("R10 sync2", 50);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    chk("R10 ignored when not slave", int'(cnt), 51);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    ten_in = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_wrap();
    t_duty();
    t_equal();
    t_shadow();
    t_trap();
    t_capture();
    t_sync_out();
    t_sync_in();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule